// File: doc/BRIEF.md
# Triple-Buffered Serial Receive Path

This block takes a serial bit stream, framed by a one-cycle frame-sync pulse, and assembles words of a selectable length (8, 12, 16, 20, 24 or 32 bits). Bits arrive most significant bit first. Each word passes through three stages: a shift stage, a holding buffer and a host-visible data register. The data register is presented as two 16-bit halves. The host reads the high half first, then strobes a read of the low half. That strobe frees the data register so the next waiting word can move up.

With three stages, the host can leave two complete words unread while a third is being shifted in. A word that finishes while both the buffer and the data register are occupied is dropped, and a sticky overrun flag is raised. An optional expansion mode treats each word as an 8-bit logarithmic PCM code, in either of the two common companding laws. The code is converted to a 16-bit signed linear sample when the word moves from the buffer into the data register.

The serial input, the frame sync and the host strobe are all sampled on the single clock `clk_i`.

Top module: `serial_rx_path`

## Requirements
- R1: A frame starts on a rising clock edge where `fs_i` is 1 and no word is in progress. On that edge, `wlen_i`, `exp_en_i` and `law_i` are latched. The word length code maps 0→8, 1→12, 2→16, 3→20, 4→24 and 5, 6, 7→32 bits. Data bit N−1 (the MSB) is sampled from `sd_i` on the next edge, and the following bits on the edges after it. Word bits [15:0] appear right-justified in `data_lo_o`, with zeros above the word length.
- R2: A word of 16 bits or fewer leaves `data_hi_o` unchanged.
- R3: For a word of more than 16 bits, word bits [N−1:16] appear in `data_hi_o[N−17:0]`, with zeros above them, and word bits [15:0] appear in `data_lo_o`.
- R4: `ready_o` rises on the second edge after the last data bit when the data register was empty. While `rd_lo_i` is 0, the data register and `ready_o` hold. A `rd_lo_i` pulse clears `ready_o` on that edge when no word is waiting in the buffer.
- R5: While the data register is full, one further complete word waits in the buffer. On the `rd_lo_i` edge it moves into the data register, and `ready_o` stays 1.
- R6: A word that completes while both the buffer and the data register are full is discarded, and the contents of both stages are kept. `overrun_o` then rises on that edge and stays 1 until reset.
- R7: With `exp_en_i`=1 and `law_i`=0, let the code c be the inverted 8-bit word, with sign s=c[7], segment e=c[6:4] and step m=c[3:0]. The magnitude is ((2m+33)·2^e)−33. `data_lo_o` receives that magnitude, negated when s=1, as a 16-bit two's complement value.
- R8: With `exp_en_i`=1 and `law_i`=1, let c be the word XOR 8'h55, with e=c[6:4] and m=c[3:0]. The magnitude is 2m+1 when e=0, and (2m+33)·2^(e−1) otherwise. The sample is positive when c[7]=1 and negative otherwise, and appears in `data_lo_o` as 16-bit two's complement.
- R9: When expansion is enabled, the word length is 8 bits whatever the value of `wlen_i`, and `data_hi_o` is unchanged.
- R10: `fs_i` pulses while a word is being shifted in are ignored.
- R11: After reset, `ready_o`, `overrun_o`, `data_hi_o` and `data_lo_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; serial and host side |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_i | input | 1 | Serial data, MSB first |
| fs_i | input | 1 | Frame sync pulse |
| wlen_i | input | 3 | Word length code |
| exp_en_i | input | 1 | Enable log-PCM expansion (forces 8-bit words) |
| law_i | input | 1 | Expansion law: 0 mu-law, 1 A-law |
| rd_lo_i | input | 1 | Host read strobe of the low half |
| data_hi_o | output | 16 | Data register high half |
| data_lo_o | output | 16 | Data register low half |
| ready_o | output | 1 | Data register holds an unread word |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default half width of 16. With that width, all six word lengths are reachable, including the split between the two halves at 20, 24 and 32 bits. Random word lengths, data and frame-sync glitches are mixed with an exhaustive sweep of all 256 codes under each expansion law, with `wlen_i` set to a wide code. A directed sequence fills all three stages, so that the overrun drop and the buffer-to-register handoff are both observed at the ports.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int HALF_W = 16;
  localparam int LEN_W  = $clog2(2 * HALF_W + 1);

  typedef struct packed {
    logic [HALF_W-1:0] hi;
    logic [HALF_W-1:0] lo;
    logic              wide;
    logic              exp;
    logic              law;
  } word_t;

  function automatic logic [LEN_W-1:0] wlen_bits(input logic [2:0] code);
    case (code)
      3'd0:    return LEN_W'(8);
      3'd1:    return LEN_W'(12);
      3'd2:    return LEN_W'(16);
      3'd3:    return LEN_W'(20);
      3'd4:    return LEN_W'(24);
      default: return LEN_W'(32);
    endcase
  endfunction

  // 8-bit log code to 16-bit two's complement linear sample
  function automatic logic [HALF_W-1:0] expand(input logic [7:0] code, input logic a_law);
    logic [7:0]  c;
    logic [2:0]  e;
    logic [5:0]  base;
    logic [13:0] mag;
    logic        neg;
    c    = a_law ? (code ^ 8'h55) : ~code;
    e    = c[6:4];
    base = {1'b0, c[3:0], 1'b0} + 6'd33;
    if (a_law) begin
      mag = (e == 3'd0) ? {9'd0, c[3:0], 1'b1} : ({8'd0, base} << (e - 3'd1));
      neg = ~c[7];
    end else begin
      mag = ({8'd0, base} << e) - 14'd33;
      neg = c[7];
    end
    return neg ? -{2'b00, mag} : {2'b00, mag};
  endfunction
endpackage

// File: rtl/rx_shift_stage.sv
module rx_shift_stage
  import serial_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sd_i,
  input  logic        fs_i,
  input  logic [2:0]  wlen_i,
  input  logic        exp_en_i,
  input  logic        law_i,
  output logic        done_o,
  output word_t       word_o
);
  logic              active_q;
  logic [LEN_W-1:0]  cnt_q, len_q;
  logic              wide_q, exp_q, law_q;
  logic [HALF_W-1:0] sh_hi_q, sh_lo_q;
  logic [LEN_W-1:0]  len_d;
  logic              last;

  assign len_d = exp_en_i ? LEN_W'(8) : wlen_bits(wlen_i);
  assign last  = (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= LEN_W'(8);
      wide_q   <= 1'b0;
      exp_q    <= 1'b0;
      law_q    <= 1'b0;
      sh_hi_q  <= '0;
      sh_lo_q  <= '0;
    end else if (!active_q) begin
      if (fs_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        len_q    <= len_d;
        wide_q   <= (len_d > LEN_W'(HALF_W));
        exp_q    <= exp_en_i;
        law_q    <= law_i;
        sh_lo_q  <= '0;
        if (len_d > LEN_W'(HALF_W)) sh_hi_q <= '0;
      end
    end else begin
      sh_lo_q <= {sh_lo_q[HALF_W-2:0], sd_i};
      if (wide_q) sh_hi_q <= {sh_hi_q[HALF_W-2:0], sh_lo_q[HALF_W-1]};
      cnt_q <= cnt_q + LEN_W'(1);
      if (last) active_q <= 1'b0;
    end
  end

  assign done_o      = active_q & last;
  assign word_o.lo   = {sh_lo_q[HALF_W-2:0], sd_i};
  assign word_o.hi   = {sh_hi_q[HALF_W-2:0], sh_lo_q[HALF_W-1]};
  assign word_o.wide = wide_q;
  assign word_o.exp  = exp_q;
  assign word_o.law  = law_q;
endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf
  import serial_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  done_i,
  input  word_t word_i,
  input  logic  take_i,
  output logic  valid_o,
  output word_t hold_o,
  output logic  drop_o
);
  logic accept;
  assign accept = done_i & (~valid_o | take_i);
  assign drop_o = done_i & ~accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      hold_o  <= '0;
    end else begin
      if (accept) begin
        valid_o     <= 1'b1;
        hold_o.lo   <= word_i.lo;
        hold_o.wide <= word_i.wide;
        hold_o.exp  <= word_i.exp;
        hold_o.law  <= word_i.law;
        if (word_i.wide) hold_o.hi <= word_i.hi;
      end else if (take_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_data_reg.sv
module rx_data_reg
  import serial_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_v_i,
  input  word_t             hold_i,
  input  logic              rd_lo_i,
  output logic              take_o,
  output logic              full_o,
  output logic [HALF_W-1:0] hi_o,
  output logic [HALF_W-1:0] lo_o
);
  logic [HALF_W-1:0] lo_d;
  assign take_o = hold_v_i & (~full_o | rd_lo_i);
  assign lo_d   = hold_i.exp ? expand(hold_i.lo[7:0], hold_i.law) : hold_i.lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      hi_o   <= '0;
      lo_o   <= '0;
    end else if (take_o) begin
      full_o <= 1'b1;
      lo_o   <= lo_d;
      if (hold_i.wide) hi_o <= hold_i.hi;
    end else if (rd_lo_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_path.sv
module serial_rx_path
  import serial_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sd_i,
  input  logic              fs_i,
  input  logic [2:0]        wlen_i,
  input  logic              exp_en_i,
  input  logic              law_i,
  input  logic              rd_lo_i,
  output logic [HALF_W-1:0] data_hi_o,
  output logic [HALF_W-1:0] data_lo_o,
  output logic              ready_o,
  output logic              overrun_o
);
  logic  done, hold_v, take, drop;
  word_t word, hold;

  rx_shift_stage u_shift (
    .clk_i, .rst_ni, .sd_i, .fs_i, .wlen_i, .exp_en_i, .law_i,
    .done_o(done), .word_o(word)
  );

  rx_hold_buf u_buf (
    .clk_i, .rst_ni, .done_i(done), .word_i(word), .take_i(take),
    .valid_o(hold_v), .hold_o(hold), .drop_o(drop)
  );

  rx_data_reg u_dreg (
    .clk_i, .rst_ni, .hold_v_i(hold_v), .hold_i(hold), .rd_lo_i,
    .take_o(take), .full_o(ready_o), .hi_o(data_hi_o), .lo_o(data_lo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   overrun_o <= 1'b0;
    else if (drop) overrun_o <= 1'b1;
  end
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_lo_i,
  input logic        ready_o,
  input logic        overrun_o,
  input logic [15:0] data_hi_o,
  input logic [15:0] data_lo_o,
  input logic        done,
  input logic        hold_v,
  input logic        take,
  input logic        hold_wide,
  input logic [15:0] hold_lo
);
  a_r4_ready_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !rd_lo_i) |=> (ready_o && $stable(data_lo_o) && $stable(data_hi_o)));

  a_r4_ready_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rd_lo_i && !hold_v) |=> !ready_o);

  a_r5_hold_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_v && !take) |=> (hold_v && $stable(hold_lo)));

  a_r5_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rd_lo_i && hold_v) |=> ready_o);

  a_r6_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && hold_v && !take) |=> overrun_o);

  a_r6_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  a_r2_hi_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !hold_wide) |=> $stable(data_hi_o));
endmodule

bind serial_rx_path serial_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_lo_i(rd_lo_i), .ready_o(ready_o),
  .overrun_o(overrun_o), .data_hi_o(data_hi_o), .data_lo_o(data_lo_o),
  .done(done), .hold_v(hold_v), .take(take), .hold_wide(hold.wide),
  .hold_lo(hold.lo)
);

// File: tb/serial_rx_path_tb.sv
`timescale 1ns/1ps
module serial_rx_path_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sd = 1'b0, fs = 1'b0, exp_en = 1'b0, law = 1'b0, rd_lo = 1'b0;
  logic [2:0]  wlen = 3'd0;
  logic [15:0] dhi, dlo;
  logic        ready, ovr;
  int          n_run = 0, n_fail = 0;
  bit          finished = 1'b0;
  logic [15:0] exp_hi = 16'h0;

  always #2.5 clk = ~clk;

  serial_rx_path u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sd_i(sd), .fs_i(fs), .wlen_i(wlen),
    .exp_en_i(exp_en), .law_i(law), .rd_lo_i(rd_lo),
    .data_hi_o(dhi), .data_lo_o(dlo), .ready_o(ready), .overrun_o(ovr)
  );

  function automatic int len_of(input logic [2:0] c);
    int t[8] = '{8, 12, 16, 20, 24, 32, 32, 32};
    return t[c];
  endfunction

  function automatic logic [15:0] lin_mu(input logic [7:0] code);
    logic [7:0] c = ~code;
    int mag = (2 * int'(c[3:0]) + 33) * (1 << c[6:4]) - 33;
    return c[7] ? 16'(-mag) : 16'(mag);
  endfunction

  function automatic logic [15:0] lin_a(input logic [7:0] code);
    logic [7:0] c = code ^ 8'h55;
    int mag = (c[6:4] == 0) ? 2 * int'(c[3:0]) + 1
                            : (2 * int'(c[3:0]) + 33) * (1 << (c[6:4] - 1));
    return c[7] ? 16'(mag) : 16'(-mag);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // ends at the negedge after the edge that samples the last bit
  task automatic send(input logic [31:0] w, input int n, input logic [2:0] wl,
                      input logic ex, input logic lw, input int glitch);
    @(negedge clk);
    fs = 1'b1; wlen = wl; exp_en = ex; law = lw;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      fs = (glitch == i);
      sd = w[i];
      wlen = 3'($urandom);
      exp_en = 1'b0;
    end
    @(negedge clk);
    fs = 1'b0; sd = 1'b0;
  endtask

  task automatic read_lo();
    @(negedge clk); rd_lo = 1'b1;
    @(negedge clk); rd_lo = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R11 ready", {31'd0, ready}, 32'd0);
    chk("R11 overrun", {31'd0, ovr}, 32'd0);
    chk("R11 data", {dhi, dlo}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // wide word, then narrow word: high half must survive
    send(32'hA5C3_1E7F, 32, 3'd5, 1'b0, 1'b0, -1);
    @(negedge clk);
    chk("R4 ready set", {31'd0, ready}, 32'd1);
    chk("R3 32-bit word", {dhi, dlo}, 32'hA5C3_1E7F);
    read_lo();
    chk("R4 ready clear", {31'd0, ready}, 32'd0);
    send(32'h0000_00B6, 8, 3'd0, 1'b0, 1'b0, -1);
    @(negedge clk);
    chk("R2 hi kept", {16'd0, dhi}, 32'h0000_A5C3);
    chk("R1 8-bit word", {16'd0, dlo}, 32'h0000_00B6);
    read_lo();
    exp_hi = 16'hA5C3;

    // random lengths, data and mid-word frame-sync glitches
    for (int k = 0; k < 80; k++) begin
      logic [2:0] wc = 3'($urandom);
      int n = len_of(wc);
      int g = ($urandom % 3 == 0) ? int'($urandom % n) : -1;
      logic [31:0] m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
      w = $urandom;
      send(w, n, wc, 1'b0, 1'b0, g);
      repeat (1 + ($urandom % 3)) @(negedge clk);
      if (n > 16) exp_hi = 16'((w & m) >> 16);
      chk(g >= 0 ? "R10 glitch ignored lo" : "R1 random lo", {16'd0, dlo}, {16'd0, 16'(w & m)});
      chk(n > 16 ? "R3 random hi" : "R2 random hi", {16'd0, dhi}, {16'd0, exp_hi});
      chk("R4 ready random", {31'd0, ready}, 32'd1);
      if ($urandom % 2) begin
        @(negedge clk);
        chk("R4 hold without read", {dhi, dlo}, {exp_hi, 16'(w & m)});
      end
      read_lo();
      chk("R4 cleared by read", {31'd0, ready}, 32'd0);
    end

    // expansion sweep; wlen_i deliberately set to a 32-bit code
    for (int lw = 0; lw < 2; lw++) begin
      for (int c = 0; c < 256; c++) begin
        send(32'(c), 8, 3'd5, 1'b1, lw[0], -1);
        @(negedge clk);
        if (lw == 0) chk("R7 mu-law expand", {16'd0, dlo}, {16'd0, lin_mu(8'(c))});
        else         chk("R8 A-law expand", {16'd0, dlo}, {16'd0, lin_a(8'(c))});
        chk("R9 forced 8-bit hi kept", {16'd0, dhi}, {16'd0, exp_hi});
        read_lo();
      end
    end

    // fill all three stages
    chk("R6 no overrun yet", {31'd0, ovr}, 32'd0);
    send(32'h0000_1111, 16, 3'd2, 1'b0, 1'b0, -1);
    send(32'h0000_2222, 16, 3'd2, 1'b0, 1'b0, -1);
    send(32'h0000_3333, 16, 3'd2, 1'b0, 1'b0, -1);
    @(negedge clk);
    chk("R6 overrun set", {31'd0, ovr}, 32'd1);
    chk("R6 data kept", {16'd0, dlo}, 32'h0000_1111);
    read_lo();
    chk("R5 handoff ready", {31'd0, ready}, 32'd1);
    chk("R5 buffered word", {16'd0, dlo}, 32'h0000_2222);
    read_lo();
    chk("R6 third word dropped", {31'd0, ready}, 32'd0);
    chk("R6 overrun sticky", {31'd0, ovr}, 32'd1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule